// File: doc/BRIEF.md
# Aliased Stereo Sample Exchange Register Bank

This block is a memory-mapped register bank that lets a processor move stereo audio samples to and from sample FIFOs with plain word loads and stores. Write-only transmit ports push one sample into a per-channel transmit FIFO. The channels are two left/right pairs, and each channel has its own queue. Read-only receive ports pop samples that a selected receive stream has delivered into a left and a right receive FIFO. Every data port answers at four consecutive word addresses, so a burst of word accesses that walks through the aliases moves several samples one after another. Each access at any alias moves exactly one entry.

Transmit and receive ports share some address ranges and are told apart only by the direction of the access. A packed stereo port carries a 16-bit left sample and a 16-bit right sample in one word. A 3-bit source-select field chooses which of several receive streams may fill the receive FIFOs. Full and empty FIFOs are handled gracefully. A write to a full transmit FIFO is dropped and raises a sticky overflow flag. A read from an empty receive FIFO returns zero and raises a sticky underflow flag.

Top module: `sample_xchg_regs`

## Requirements
- R1: After a synchronous active-high reset, `tx_valid` is all zero, `bus_rdata` is zero, both sticky flags are low and the source select is 0, so that with empty receive FIFOs `rx_ready` is 8'b0000_0001.
- R2: Each transmit port answers at four word addresses (base, base+4, base+8, base+0xC). A write at any of them pushes exactly one entry, and entries leave the FIFO in write order.
- R3: Transmit channel bases are 0x34 (channel 0, pair 0 left), 0x44 (channel 1, pair 0 right), 0x54 (channel 2, pair 1 left) and 0x64 (channel 3, pair 1 right). Channel n is presented on `tx_data[32n+31:32n]` and `tx_valid[n]`.
- R4: A write to the packed port (0x74–0x80) takes bits 31:16 as left and bits 15:0 as right. It sign-extends each half to 32 bits and pushes them together into channels 0 and 1.
- R5: A write to a full 8-entry transmit FIFO is dropped and sets the sticky `ovf_flag`. A packed write is dropped whole when either channel 0 or channel 1 is full.
- R6: At shared ranges the direction decides. A write at 0x64–0x70 pushes channel 3 and leaves the receive FIFOs untouched. A read there pops the receive right FIFO and pushes no transmit channel.
- R7: Reads of the receive left port (0x54–0x60) or right port (0x64–0x70) at any alias pop one entry in arrival order. A read of the packed receive port (0x74–0x80) pops both and returns {left[15:0], right[15:0]}. `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds until the next read.
- R8: A read of an empty receive port returns zero, pops nothing and sets the sticky `unf_flag`. The packed read behaves this way unless both receive FIFOs hold data.
- R9: Writing bits 2:0 at address 0x00 selects the receive source, and a read at 0x00 returns it zero-extended. Only the selected stream's `rx_ready` can be high, and only that stream's samples enter the receive FIFOs.
- R10: A read at an unmapped, misaligned or transmit-only address returns zero and pops nothing. A write there changes no FIFO and no register.
- R11: Each receive FIFO holds 8 entries. `rx_ready` of the selected stream falls when either receive FIFO is full, and transmit entries leave only on `tx_valid` and `tx_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 128 | Head sample of each transmit channel, 32 bits per channel |
| tx_valid | output | 4 | Transmit channel holds data |
| tx_ready | input | 4 | Consumer takes the head sample |
| rx_left | input | 256 | Left sample of each receive stream, 32 bits per stream |
| rx_right | input | 256 | Right sample of each receive stream, 32 bits per stream |
| rx_valid | input | 8 | Receive stream offers a sample pair |
| rx_ready | output | 8 | Receive stream's pair is accepted |
| ovf_flag | output | 1 | Sticky: a transmit write was dropped |
| unf_flag | output | 1 | Sticky: a receive read found no data |

## Verification
Writes walk through all four aliases of a port with distinct values, so that a design which decodes only the base address, or that moves zero or two entries per access, shows up in the drained order. Packed words with the sign bit set in one half and clear in the other separate correct sign extension and half placement from swapped or zero-extended halves. Writes and reads at the shared 0x64 range are each done while the opposite FIFO holds data, which exposes direction confusion. Fill-to-full, overflow, empty reads and a competing unselected stream probe the boundaries and the source multiplexer.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
  localparam int unsigned CMP_W      = 16;
  localparam logic [CMP_W-1:0] CTRL_ADDR = 16'h0000;
  localparam logic [CMP_W-1:0] TX_BASE0  = 16'h0034;
  localparam logic [CMP_W-1:0] PORT_STEP = 16'h0010;
  localparam logic [CMP_W-1:0] LAST_ALIAS = 16'h000C;

  // True when a lies on one of the four word aliases starting at base
  function automatic logic alias_hit(input logic [CMP_W-1:0] a,
                                     input logic [CMP_W-1:0] base);
    return (a[1:0] == 2'b00) && (a >= base) && (a <= base + LAST_ALIAS);
  endfunction

  function automatic logic [CMP_W-1:0] port_base(input int unsigned idx);
    return TX_BASE0 + CMP_W'(idx) * PORT_STEP;
  endfunction
endpackage

// File: rtl/sxr_fifo.sv
module sxr_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11: occupancy never exceeds the depth
  p_count_bounded_r11: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  // R5: a push into a full queue with no pop leaves it full
  p_drop_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full);
  // R8: a pop of an empty queue with no push leaves it empty
  p_no_pop_when_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/sxr_decode.sv
module sxr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_TX   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [N_TX-1:0]   wr_tx,
  output logic              wr_pack,
  output logic              wr_ctrl,
  output logic              rd_ctrl,
  output logic              rd_left,
  output logic              rd_right,
  output logic              rd_pack,
  output logic              rd_hit
);
  import sxr_pkg::*;

  localparam logic [CMP_W-1:0] PACK_BASE = port_base(N_TX);
  localparam logic [CMP_W-1:0] RXL_BASE  = port_base(N_TX - 2);
  localparam logic [CMP_W-1:0] RXR_BASE  = port_base(N_TX - 1);

  logic [CMP_W-1:0] a;
  assign a = CMP_W'(addr);

  for (genvar i = 0; i < N_TX; i++) begin : g_tx
    assign wr_tx[i] = wr && alias_hit(a, port_base(i));
  end

  assign wr_pack  = wr && alias_hit(a, PACK_BASE);
  assign wr_ctrl  = wr && (a == CTRL_ADDR);
  assign rd_ctrl  = rd && (a == CTRL_ADDR);
  assign rd_left  = rd && alias_hit(a, RXL_BASE);
  assign rd_right = rd && alias_hit(a, RXR_BASE);
  assign rd_pack  = rd && alias_hit(a, PACK_BASE);
  assign rd_hit   = rd_ctrl || rd_left || rd_right || rd_pack;
endmodule

// File: rtl/sxr_rx_mux.sv
module sxr_rx_mux #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [SEL_W-1:0]       sel,
  input  logic [N_SRC-1:0]       valid,
  input  logic [N_SRC*WIDTH-1:0] left,
  input  logic [N_SRC*WIDTH-1:0] right,
  input  logic                   accept,
  output logic                   sel_valid,
  output logic [WIDTH-1:0]       sel_left,
  output logic [WIDTH-1:0]       sel_right,
  output logic [N_SRC-1:0]       ready
);
  assign sel_valid = valid[sel];
  assign sel_left  = left[sel*WIDTH +: WIDTH];
  assign sel_right = right[sel*WIDTH +: WIDTH];

  for (genvar i = 0; i < N_SRC; i++) begin : g_rdy
    assign ready[i] = (sel == SEL_W'(i)) && accept;
  end
endmodule

// File: rtl/sample_xchg_regs.sv
module sample_xchg_regs #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned N_PAIRS    = 2,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned N_SRC      = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [2*N_PAIRS*DATA_W-1:0] tx_data,
  output logic [2*N_PAIRS-1:0]      tx_valid,
  input  logic [2*N_PAIRS-1:0]      tx_ready,
  input  logic [N_SRC*DATA_W-1:0]   rx_left,
  input  logic [N_SRC*DATA_W-1:0]   rx_right,
  input  logic [N_SRC-1:0]          rx_valid,
  output logic [N_SRC-1:0]          rx_ready,
  output logic                      ovf_flag,
  output logic                      unf_flag
);
  localparam int unsigned N_TX   = 2 * N_PAIRS;
  localparam int unsigned SEL_W  = $clog2(N_SRC);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [N_TX-1:0] wr_tx;
  logic wr_pack, wr_ctrl, rd_ctrl, rd_left, rd_right, rd_pack, rd_hit;

  sxr_decode #(.ADDR_W(ADDR_W), .N_TX(N_TX)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_tx(wr_tx), .wr_pack(wr_pack), .wr_ctrl(wr_ctrl),
    .rd_ctrl(rd_ctrl), .rd_left(rd_left), .rd_right(rd_right),
    .rd_pack(rd_pack), .rd_hit(rd_hit)
  );

  // receive source select
  logic [SEL_W-1:0] src_sel;
  always_ff @(posedge clk) begin
    if (rst)          src_sel <= '0;
    else if (wr_ctrl) src_sel <= bus_wdata[SEL_W-1:0];
  end

  // transmit side
  logic [N_TX-1:0] tx_full, tx_empty;
  logic            pack_ok;
  logic [DATA_W-1:0] pack_l, pack_r;

  assign pack_ok = wr_pack && !tx_full[0] && !tx_full[1];
  assign pack_l  = {{HALF_W{bus_wdata[DATA_W-1]}}, bus_wdata[DATA_W-1:HALF_W]};
  assign pack_r  = {{HALF_W{bus_wdata[HALF_W-1]}}, bus_wdata[HALF_W-1:0]};

  for (genvar i = 0; i < N_TX; i++) begin : g_tx
    logic              push_i;
    logic [DATA_W-1:0] din_i;
    if (i < 2) begin : g_packed_target
      assign push_i = wr_tx[i] || pack_ok;
      assign din_i  = wr_pack ? ((i == 0) ? pack_l : pack_r) : bus_wdata;
    end else begin : g_plain
      assign push_i = wr_tx[i];
      assign din_i  = bus_wdata;
    end
    sxr_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst(rst), .push(push_i), .din(din_i),
      .pop(tx_ready[i]), .dout(tx_data[i*DATA_W +: DATA_W]),
      .full(tx_full[i]), .empty(tx_empty[i])
    );
    assign tx_valid[i] = !tx_empty[i];
  end

  // receive side
  logic              sel_valid, rx_accept;
  logic [DATA_W-1:0] sel_l, sel_r, rxl_q, rxr_q;
  logic              rxl_full, rxl_empty, rxr_full, rxr_empty;
  logic              rx_push, rxl_pop, rxr_pop, pack_rd_ok;

  assign rx_accept = !rxl_full && !rxr_full;
  assign rx_push   = sel_valid && rx_accept;

  sxr_rx_mux #(.N_SRC(N_SRC), .WIDTH(DATA_W)) u_mux (
    .sel(src_sel), .valid(rx_valid), .left(rx_left), .right(rx_right),
    .accept(rx_accept), .sel_valid(sel_valid), .sel_left(sel_l),
    .sel_right(sel_r), .ready(rx_ready)
  );

  assign pack_rd_ok = rd_pack && !rxl_empty && !rxr_empty;
  assign rxl_pop    = rd_left || pack_rd_ok;
  assign rxr_pop    = rd_right || pack_rd_ok;

  sxr_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxl (
    .clk(clk), .rst(rst), .push(rx_push), .din(sel_l), .pop(rxl_pop),
    .dout(rxl_q), .full(rxl_full), .empty(rxl_empty)
  );
  sxr_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxr (
    .clk(clk), .rst(rst), .push(rx_push), .din(sel_r), .pop(rxr_pop),
    .dout(rxr_q), .full(rxr_full), .empty(rxr_empty)
  );

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (rd_ctrl)
        bus_rdata <= DATA_W'(src_sel);
      else if (rd_left)
        bus_rdata <= rxl_empty ? '0 : rxl_q;
      else if (rd_right)
        bus_rdata <= rxr_empty ? '0 : rxr_q;
      else if (pack_rd_ok)
        bus_rdata <= {rxl_q[HALF_W-1:0], rxr_q[HALF_W-1:0]};
      else
        bus_rdata <= '0;
    end
  end

  // sticky error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      if (|(wr_tx & tx_full) || (wr_pack && !pack_ok)) ovf_flag <= 1'b1;
      if ((rd_left && rxl_empty) || (rd_right && rxr_empty) ||
          (rd_pack && !pack_rd_ok))                     unf_flag <= 1'b1;
    end
  end

  // R9: at most one stream is offered ready
  p_single_ready_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_ready));
  // R5: overflow flag never clears without reset
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
  // R8: underflow flag never clears without reset
  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);
  // R10: a read that hits no port returns zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !rd_hit) |=> (bus_rdata == '0));
  // R6: one access never targets both a transmit channel and the packed port
  p_single_write_target_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_tx, wr_pack, wr_ctrl}) <= 1);
  // R7: bus_rdata holds between reads
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sample_xchg_regs_bench.sv
`timescale 1ns/1ps
module sample_xchg_regs_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   bus_addr;
  logic         bus_wr, bus_rd;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [127:0] tx_data;
  logic [3:0]   tx_valid, tx_ready;
  logic [255:0] rx_left, rx_right;
  logic [7:0]   rx_valid, rx_ready;
  logic         ovf_flag, unf_flag;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  sample_xchg_regs u_sample_xchg_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tx_pop(input int ch, output logic [31:0] d, output logic v);
    @(negedge clk);
    v = tx_valid[ch];
    d = tx_data[ch*32 +: 32];
    tx_ready[ch] = 1'b1;
    @(negedge clk);
    tx_ready[ch] = 1'b0;
  endtask

  task automatic expect_tx(input string req, input int ch, input logic [31:0] exp);
    logic [31:0] d; logic v;
    tx_pop(ch, d, v);
    check(req, {31'b0, v}, 32'd1);
    check(req, d, exp);
  endtask

  task automatic rx_push(input int s, input logic [31:0] l, input logic [31:0] r,
                         output logic acc);
    @(negedge clk);
    acc = rx_ready[s];
    rx_valid[s] = 1'b1;
    rx_left[s*32 +: 32] = l;
    rx_right[s*32 +: 32] = r;
    @(negedge clk);
    rx_valid[s] = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 tx_valid", {28'b0, tx_valid}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 flags", {30'b0, ovf_flag, unf_flag}, 32'h0);
    check("R1 rx_ready", {24'b0, rx_ready}, 32'h1);
  endtask

  task automatic t_alias_write;
    for (int k = 0; k < 4; k++) bus_write(8'h34 + 8'(4*k), 32'hA000_0000 + k);
    bus_write(8'h48, 32'h1111_0001);
    bus_write(8'h5C, 32'h2222_0002);
    bus_write(8'h70, 32'h3333_0003);
    check("R3 all channels loaded", {28'b0, tx_valid}, 32'hF);
    for (int k = 0; k < 4; k++) expect_tx("R2 alias order ch0", 0, 32'hA000_0000 + k);
    check("R2 one entry per alias", {31'b0, tx_valid[0]}, 32'h0);
    expect_tx("R3 ch1", 1, 32'h1111_0001);
    expect_tx("R3 ch2", 2, 32'h2222_0002);
    expect_tx("R3 ch3", 3, 32'h3333_0003);
    check("R11 drained", {28'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_packed_write;
    bus_write(8'h78, 32'h8001_7FFF);
    check("R4 only pair 0", {28'b0, tx_valid}, 32'h3);
    expect_tx("R4 left sign-ext", 0, 32'hFFFF_8001);
    expect_tx("R4 right sign-ext", 1, 32'h0000_7FFF);
    bus_write(8'h80, 32'h1234_F00D);
    expect_tx("R4 left positive", 0, 32'h0000_1234);
    expect_tx("R4 right negative", 1, 32'hFFFF_F00D);
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 8; k++) bus_write(8'h54 + 8'(4*(k%4)), 32'hC0 + k);
    check("R5 no ovf at depth", {31'b0, ovf_flag}, 32'h0);
    bus_write(8'h58, 32'hDEAD);
    check("R5 ovf set", {31'b0, ovf_flag}, 32'h1);
    for (int k = 0; k < 8; k++) expect_tx("R5 kept entries", 2, 32'hC0 + k);
    check("R5 ninth dropped", {31'b0, tx_valid[2]}, 32'h0);
    for (int k = 0; k < 8; k++) bus_write(8'h34, 32'hE0 + k);
    bus_write(8'h74, 32'h0005_0006);
    check("R5 packed dropped whole", {31'b0, tx_valid[1]}, 32'h0);
    for (int k = 0; k < 8; k++) expect_tx("R5 ch0 intact", 0, 32'hE0 + k);
    check("R5 ovf still set", {31'b0, ovf_flag}, 32'h1);
  endtask

  task automatic t_rx_read;
    logic [31:0] d; logic acc;
    bus_write(8'h00, 32'hFFFF_FFFB);
    bus_read(8'h00, d);
    check("R9 select readback", d, 32'h3);
    check("R9 ready on stream 3", {24'b0, rx_ready}, 32'h08);
    rx_valid[0] = 1'b1;
    rx_left[31:0] = 32'hBAD0_BAD0; rx_right[31:0] = 32'hBAD1_BAD1;
    for (int k = 0; k < 3; k++) begin
      rx_push(3, 32'h1000_0A00 + k, 32'h2000_0B00 + k, acc);
      check("R9 selected accepted", {31'b0, acc}, 32'h1);
    end
    rx_valid[0] = 1'b0;
    bus_read(8'h64, d); check("R7 right first", d, 32'h2000_0B00);
    bus_read(8'h6C, d); check("R7 right alias", d, 32'h2000_0B01);
    bus_read(8'h54, d); check("R7 left first", d, 32'h1000_0A00);
    check("R8 no underflow yet", {31'b0, unf_flag}, 32'h0);
    bus_read(8'h7C, d); check("R7 packed read", d, 32'h0A01_0B02);
    bus_read(8'h74, d); check("R8 packed needs both", d, 32'h0);
    check("R8 unf set", {31'b0, unf_flag}, 32'h1);
    bus_read(8'h60, d); check("R8 left not popped by failed packed", d, 32'h1000_0A02);
    bus_read(8'h68, d); check("R8 empty right reads zero", d, 32'h0);
  endtask

  task automatic t_overlap;
    logic [31:0] d; logic acc;
    rx_push(3, 32'h5555_0005, 32'h6666_0006, acc);
    bus_write(8'h68, 32'h7777_0007);
    check("R6 write hits ch3 only", {28'b0, tx_valid}, 32'h8);
    bus_read(8'h70, d); check("R6 rx right not popped by write", d, 32'h6666_0006);
    expect_tx("R6 ch3 data", 3, 32'h7777_0007);
    bus_read(8'h64, d);
    check("R6 read pushes no tx", {28'b0, tx_valid}, 32'h0);
    bus_read(8'h54, d); check("R7 left leftover", d, 32'h5555_0005);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic acc;
    rx_push(3, 32'h0000_0C0C, 32'h0000_0D0D, acc);
    bus_read(8'h00, d); check("R9 select kept", d, 32'h3);
    bus_read(8'h44, d); check("R10 tx-only read zero", d, 32'h0);
    bus_read(8'h84, d); check("R10 beyond range zero", d, 32'h0);
    bus_read(8'h66, d); check("R10 misaligned zero", d, 32'h0);
    bus_write(8'h90, 32'h1); bus_write(8'h30, 32'h2); bus_write(8'h36, 32'h3);
    check("R10 writes ignored", {28'b0, tx_valid}, 32'h0);
    bus_read(8'h00, d); check("R10 select unchanged", d, 32'h3);
    bus_read(8'h64, d); check("R10 no pop", d, 32'h0000_0D0D);
    bus_read(8'h54, d); check("R10 left intact", d, 32'h0000_0C0C);
  endtask

  task automatic t_rx_full;
    logic [31:0] d; logic acc;
    for (int k = 0; k < 8; k++) begin
      rx_push(3, 32'h300 + k, 32'h400 + k, acc);
      check("R11 accepted below depth", {31'b0, acc}, 32'h1);
    end
    check("R11 ready low when full", {24'b0, rx_ready}, 32'h0);
    rx_push(3, 32'h3FF, 32'h4FF, acc);
    for (int k = 0; k < 8; k++) begin
      bus_read(8'h64 + 8'(4*(k%4)), d); check("R11 right order", d, 32'h400 + k);
      bus_read(8'h54, d);               check("R11 left order", d, 32'h300 + k);
    end
    bus_read(8'h64, d); check("R11 ninth not stored", d, 32'h0);
    bus_write(8'h00, 32'h0);
    check("R9 reselect stream 0", {24'b0, rx_ready}, 32'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    tx_ready = '0; rx_left = '0; rx_right = '0; rx_valid = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_alias_write;
    t_packed_write;
    t_overflow;
    t_rx_read;
    t_overlap;
    t_unmapped;
    t_rx_full;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule